// File: doc/BRIEF.md
# Potentiometer Step Sequencer

This block is the host-side master for a digital potentiometer that is moved by three control wires: an active-low select, a direction level and an active-low step strobe. The host hands it one command through a valid/ready handshake: a direction, a number of steps and a flag that says whether the final wiper position should be kept in the part's nonvolatile memory. The block then selects the part, sets the direction, issues the step pulses and deselects it. Every minimum time is honoured, and each is given as a parameter in clock cycles.

When the flag asks for a store, the strobe is high as select rises, and the long store deselect interval is awaited. Without a store, the strobe is held low as select rises, and only the short deselect interval is awaited. A single-cycle `done` pulse marks the end of the deselect interval. A step count of zero still produces a select and a deselect, so that the present position can be stored.

The command port has no buffering. `cmd_ready` is high only while the block is idle. A command is taken on the clock edge where `cmd_valid` and `cmd_ready` are both high. While a command is in progress, the block ignores `cmd_valid` and the command fields. A host that holds `cmd_valid` high simply waits until the block becomes idle again.

Top module: `pot_step_driver`

## Requirements
- R1: After reset and whenever idle, `pot_cs_n` and `pot_inc_n` are 1, `cmd_ready` is 1 and `done` is 0. A command is taken only on an edge with `cmd_valid` and `cmd_ready` both 1.
- R2: `pot_cs_n` is 0 for at least T_CS_SETUP cycles before the first falling edge of `pot_inc_n`.
- R3: While `pot_cs_n` is 0, `pot_up` equals the accepted direction (1 = up, 0 = down) and does not change. It has been stable for at least T_DIR_SETUP cycles before every falling edge of `pot_inc_n`.
- R4: Exactly `cmd_steps` falling edges of `pot_inc_n` occur while `pot_cs_n` is 0. Each low pulse lasts at least T_INC_LOW cycles, and each high time between two pulses lasts at least T_INC_HIGH cycles.
- R5: At least T_INC_TO_CS cycles pass between the last change of `pot_inc_n` and the rise of `pot_cs_n`. `pot_cs_n` and `pot_inc_n` never change in the same cycle.
- R6: With `cmd_store` = 1, `pot_inc_n` is 1 when `pot_cs_n` rises, and `pot_cs_n` stays 1 for at least T_DESEL_STORE cycles up to and including the `done` cycle.
- R7: With `cmd_store` = 0, `pot_inc_n` is 0 when `pot_cs_n` rises, and `pot_cs_n` stays 1 for at least T_DESEL_NOSTORE cycles up to and including the `done` cycle.
- R8: A command with zero steps selects and deselects the part with no strobe edge while it is selected. For a zero-step command without store, `pot_inc_n` is lowered while `pot_cs_n` is still 1.
- R9: `done` is a one-cycle pulse, issued once per command. `cmd_ready` is 0 from acceptance until after `done`. The block ignores `cmd_valid` and the command fields while it is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_up | input | 1 | Direction, 1 = up |
| cmd_steps | input | CNT_W | Number of step pulses |
| cmd_store | input | 1 | 1 = keep final position in nonvolatile memory |
| done | output | 1 | One-cycle pulse when the deselect interval ends |
| pot_cs_n | output | 1 | Active-low select to the potentiometer |
| pot_up | output | 1 | Direction level to the potentiometer |
| pot_inc_n | output | 1 | Step strobe; the wiper moves on its falling edge |

## Verification
The assertions take for granted that every timing parameter is at least one cycle. They also assume that reset is released away from a command, so every counted interval starts after reset. They rely on nothing about the command fields beyond the acceptance edge. The block samples those fields only there, and the bench deliberately changes direction, count and store flag while a command is in progress to show that they are ignored. All stimulus changes on the falling clock edge, so it never races the sampling edge.

// File: rtl/pot_step_pkg.sv
package pot_step_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETDIR,
    ST_INC_LOW,
    ST_INC_HIGH,
    ST_PRE_DESEL,
    ST_DESEL_WAIT,
    ST_DONE
  } pot_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pot_step_timer.sv
// Shared interval timer: a load of L makes the owning state last L cycles.
module pot_step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_len,
  output logic [W-1:0] count,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_len - W'(1);
    end else if (count != '0) begin
      count <= count - W'(1);
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/pot_step_counter.sv
// Remaining-step counter for one command.
module pot_step_counter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last,
  output logic         empty
);

  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
    end else if (load) begin
      left <= load_val;
    end else if (dec && left != '0) begin
      left <= left - W'(1);
    end
  end

  assign last  = (left == W'(1));
  assign empty = (left == '0);

endmodule

// File: rtl/pot_step_seq.sv
// Sequencer: walks the select / direction / strobe / deselect phases and
// registers the three pins so they never glitch.
module pot_step_seq
  import pot_step_pkg::*;
#(
  parameter int unsigned T_CS_SETUP      = 10,
  parameter int unsigned T_DIR_SETUP     = 100,
  parameter int unsigned T_INC_LOW       = 100,
  parameter int unsigned T_INC_HIGH      = 100,
  parameter int unsigned T_INC_TO_CS     = 100,
  parameter int unsigned T_DESEL_NOSTORE = 10,
  parameter int unsigned T_DESEL_STORE   = 2000000,
  parameter int unsigned TMR_W           = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_up,
  input  logic             cmd_store,
  input  logic             cmd_is_zero,
  output logic             cmd_ready,
  output logic             done,
  input  logic             tmr_zero,
  input  logic [TMR_W-1:0] tmr_count,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_len,
  output logic             cnt_load,
  output logic             cnt_dec,
  input  logic             cnt_last,
  input  logic             cnt_empty,
  output logic             pot_cs_n,
  output logic             pot_inc_n,
  output logic             pot_up
);

  localparam logic [TMR_W-1:0] L_CS     = TMR_W'(T_CS_SETUP);
  localparam logic [TMR_W-1:0] L_CS2    = TMR_W'(2 * T_CS_SETUP);
  localparam logic [TMR_W-1:0] L_DIR    = TMR_W'(T_DIR_SETUP);
  localparam logic [TMR_W-1:0] L_LOW    = TMR_W'(T_INC_LOW);
  localparam logic [TMR_W-1:0] L_HIGH   = TMR_W'(T_INC_HIGH);
  localparam logic [TMR_W-1:0] L_GAP    = TMR_W'(T_INC_TO_CS);
  localparam logic [TMR_W-1:0] L_DS_NO  = TMR_W'(T_DESEL_NOSTORE);
  localparam logic [TMR_W-1:0] L_DS_YES = TMR_W'(T_DESEL_STORE);

  pot_state_e state, nxt;
  logic       store_q, zero_q, up_q;
  logic       quiet_zero;   // zero steps and no store
  logic       accept;
  logic       sel_hold, cs_low, inc_low;
  logic       cs_n_q, inc_n_q;

  assign accept     = (state == ST_IDLE) && cmd_valid;
  assign quiet_zero = zero_q && !store_q;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_len  = '0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmd_valid) begin
          nxt      = ST_SELECT;
          tmr_load = 1'b1;
          tmr_len  = (cmd_is_zero && !cmd_store) ? L_CS2 : L_CS;
          cnt_load = 1'b1;
        end
      end
      ST_SELECT: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (zero_q) begin
            nxt     = ST_PRE_DESEL;
            tmr_len = L_GAP;
          end else begin
            nxt     = ST_SETDIR;
            tmr_len = L_DIR;
          end
        end
      end
      ST_SETDIR: begin
        if (tmr_zero) begin
          nxt      = ST_INC_LOW;
          tmr_load = 1'b1;
          tmr_len  = L_LOW;
        end
      end
      ST_INC_LOW: begin
        if (tmr_zero) begin
          cnt_dec  = 1'b1;
          tmr_load = 1'b1;
          if (cnt_last && !store_q) begin
            nxt     = ST_PRE_DESEL;
            tmr_len = L_GAP;
          end else begin
            nxt     = ST_INC_HIGH;
            tmr_len = L_HIGH;
          end
        end
      end
      ST_INC_HIGH: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (cnt_empty) begin
            nxt     = ST_PRE_DESEL;
            tmr_len = L_GAP;
          end else begin
            nxt     = ST_INC_LOW;
            tmr_len = L_LOW;
          end
        end
      end
      ST_PRE_DESEL: begin
        if (tmr_zero) begin
          nxt      = ST_DESEL_WAIT;
          tmr_load = 1'b1;
          tmr_len  = store_q ? L_DS_YES : L_DS_NO;
        end
      end
      ST_DESEL_WAIT: begin
        if (tmr_zero) nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // Quiet zero-step command: first half of SELECT lowers the strobe while
  // the part is still deselected, second half selects it.
  assign sel_hold = (state == ST_SELECT) && quiet_zero && (tmr_count >= L_CS);
  assign cs_low   = (state inside {ST_SELECT, ST_SETDIR, ST_INC_LOW, ST_INC_HIGH, ST_PRE_DESEL})
                    && !sel_hold;
  assign inc_low  = (state == ST_INC_LOW)
                    || (!store_q && (state inside {ST_PRE_DESEL, ST_DESEL_WAIT}))
                    || (quiet_zero && state == ST_SELECT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      store_q <= 1'b0;
      zero_q  <= 1'b0;
      up_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      inc_n_q <= 1'b1;
    end else begin
      state   <= nxt;
      cs_n_q  <= !cs_low;
      inc_n_q <= !inc_low;
      if (accept) begin
        store_q <= cmd_store;
        zero_q  <= cmd_is_zero;
        up_q    <= cmd_up;
      end
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign pot_cs_n  = cs_n_q;
  assign pot_inc_n = inc_n_q;
  assign pot_up    = up_q;

endmodule

// File: rtl/pot_step_driver.sv
module pot_step_driver
  import pot_step_pkg::*;
#(
  parameter int unsigned CNT_W           = 7,
  parameter int unsigned T_CS_SETUP      = 10,
  parameter int unsigned T_DIR_SETUP     = 100,
  parameter int unsigned T_INC_LOW       = 100,
  parameter int unsigned T_INC_HIGH      = 100,
  parameter int unsigned T_INC_TO_CS     = 100,
  parameter int unsigned T_DESEL_NOSTORE = 10,
  parameter int unsigned T_DESEL_STORE   = 2000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_up,
  input  logic [CNT_W-1:0] cmd_steps,
  input  logic             cmd_store,
  output logic             done,
  output logic             pot_cs_n,
  output logic             pot_up,
  output logic             pot_inc_n
);

  localparam int unsigned MAX_T =
    max2(max2(max2(2 * T_CS_SETUP, T_DIR_SETUP), max2(T_INC_LOW, T_INC_HIGH)),
         max2(T_INC_TO_CS, max2(T_DESEL_NOSTORE, T_DESEL_STORE)));
  localparam int unsigned TMR_W = $clog2(MAX_T + 1);

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_len, tmr_count;
  logic             cnt_load, cnt_dec, cnt_last, cnt_empty;
  logic             is_zero;

  assign is_zero = (cmd_steps == '0);

  pot_step_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_len (tmr_len),
    .count    (tmr_count),
    .zero     (tmr_zero)
  );

  pot_step_counter #(.W(CNT_W)) u_steps (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cmd_steps),
    .dec      (cnt_dec),
    .last     (cnt_last),
    .empty    (cnt_empty)
  );

  pot_step_seq #(
    .T_CS_SETUP      (T_CS_SETUP),
    .T_DIR_SETUP     (T_DIR_SETUP),
    .T_INC_LOW       (T_INC_LOW),
    .T_INC_HIGH      (T_INC_HIGH),
    .T_INC_TO_CS     (T_INC_TO_CS),
    .T_DESEL_NOSTORE (T_DESEL_NOSTORE),
    .T_DESEL_STORE   (T_DESEL_STORE),
    .TMR_W           (TMR_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_up      (cmd_up),
    .cmd_store   (cmd_store),
    .cmd_is_zero (is_zero),
    .cmd_ready   (cmd_ready),
    .done        (done),
    .tmr_zero    (tmr_zero),
    .tmr_count   (tmr_count),
    .tmr_load    (tmr_load),
    .tmr_len     (tmr_len),
    .cnt_load    (cnt_load),
    .cnt_dec     (cnt_dec),
    .cnt_last    (cnt_last),
    .cnt_empty   (cnt_empty),
    .pot_cs_n    (pot_cs_n),
    .pot_inc_n   (pot_inc_n),
    .pot_up      (pot_up)
  );

endmodule

// File: rtl/pot_step_driver_chk.sv
module pot_step_driver_chk #(
  parameter int unsigned T_INC_LOW       = 100,
  parameter int unsigned T_DESEL_NOSTORE = 10,
  parameter int unsigned T_DESEL_STORE   = 2000000
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic done,
  input logic pot_cs_n,
  input logic pot_up,
  input logic pot_inc_n
);

  logic cs_prev, inc_prev, rise_inc;
  int   hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_prev  <= 1'b1;
      inc_prev <= 1'b1;
      rise_inc <= 1'b1;
      hi_cnt   <= 0;
      lo_cnt   <= 0;
    end else begin
      cs_prev  <= pot_cs_n;
      inc_prev <= pot_inc_n;
      if (pot_cs_n && !cs_prev) begin
        hi_cnt   <= 1;
        rise_inc <= pot_inc_n;
      end else if (pot_cs_n && hi_cnt < 32'h3fff_ffff) begin
        hi_cnt <= hi_cnt + 1;
      end
      if (!pot_inc_n && inc_prev)                      lo_cnt <= 1;
      else if (!pot_inc_n && lo_cnt < 32'h3fff_ffff)   lo_cnt <= lo_cnt + 1;
    end
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (pot_cs_n && pot_inc_n && !done));

  // R5
  no_joint_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(pot_cs_n) && !$stable(pot_inc_n)));

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pot_cs_n && $past(!pot_cs_n)) |-> $stable(pot_up));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pot_cs_n && $rose(pot_inc_n)) |-> (lo_cnt >= int'(T_INC_LOW)));

  // R6 R7
  desel_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pot_cs_n && (hi_cnt + 1 >= (rise_inc ? int'(T_DESEL_STORE) : int'(T_DESEL_NOSTORE)))));

endmodule

bind pot_step_driver pot_step_driver_chk #(
  .T_INC_LOW       (T_INC_LOW),
  .T_DESEL_NOSTORE (T_DESEL_NOSTORE),
  .T_DESEL_STORE   (T_DESEL_STORE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .done      (done),
  .pot_cs_n  (pot_cs_n),
  .pot_up    (pot_up),
  .pot_inc_n (pot_inc_n)
);

// File: tb/pot_step_driver_bench.sv
module pot_step_driver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 7;
  localparam int T_CS = 2, T_DIR = 3, T_IL = 4, T_IH = 3, T_IC = 2, T_NS = 3, T_ST = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_up = 1'b0, cmd_store = 1'b0;
  logic [CNT_W-1:0] cmd_steps = '0;
  logic cmd_ready, done, pot_cs_n, pot_up, pot_inc_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_step_driver #(
    .CNT_W(CNT_W), .T_CS_SETUP(T_CS), .T_DIR_SETUP(T_DIR), .T_INC_LOW(T_IL),
    .T_INC_HIGH(T_IH), .T_INC_TO_CS(T_IC), .T_DESEL_NOSTORE(T_NS), .T_DESEL_STORE(T_ST)
  ) u_pot_step_driver (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_up(cmd_up), .cmd_steps(cmd_steps), .cmd_store(cmd_store), .done(done),
    .pot_cs_n(pot_cs_n), .pot_up(pot_up), .pot_inc_n(pot_inc_n)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // pin monitor state
  logic prev_cs, prev_inc, prev_up, exp_up, inc_at_rise, inc_at_fall;
  int inc_run, cs_run, up_run, falls, cs_falls, csb, min_up, min_low, min_high;
  int gap, simul, up_chg, up_bad, ready_busy, done_cnt, desel;
  bit hold;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    falls = 0; cs_falls = 0; csb = 0; min_up = 1000000; min_low = 1000000; min_high = 1000000;
    gap = 0; simul = 0; up_chg = 0; up_bad = 0; ready_busy = 0; done_cnt = 0; desel = 0;
    inc_at_rise = 1'bx; inc_at_fall = 1'bx;
  endtask

  task automatic sample();
    logic cs, inc, up;
    bit inc_ch, cs_ch;
    cs = pot_cs_n; inc = pot_inc_n; up = pot_up;
    inc_ch = (inc != prev_inc);
    cs_ch  = (cs != prev_cs);
    if (inc_ch && cs_ch) simul++;
    if (inc_ch && !inc && !cs && !prev_cs) begin
      falls++;
      if (falls == 1) csb = cs_run;
      if (up_run < min_up) min_up = up_run;
      if (falls > 1 && inc_run < min_high) min_high = inc_run;
    end
    if (inc_ch && inc && !cs && !prev_cs && inc_run < min_low) min_low = inc_run;
    if (cs_ch && !cs) begin cs_falls++; inc_at_fall = inc; end
    if (cs_ch && cs)  begin inc_at_rise = inc; gap = inc_run; end
    if (!cs && !prev_cs && up != prev_up) up_chg++;
    if (!cs && up != exp_up) up_bad++;
    if (!cs && cmd_ready) ready_busy++;
    if (done) begin
      done_cnt++;
      desel = cs ? cs_run + 1 : 0;
      if (hold) cmd_valid = 1'b0;
    end
    inc_run = inc_ch ? 1 : inc_run + 1;
    cs_run  = cs_ch ? 1 : cs_run + 1;
    up_run  = (up != prev_up) ? 1 : up_run + 1;
    prev_cs = cs; prev_inc = inc; prev_up = up;
  endtask

  task automatic tick();
    @(negedge clk);
    sample();
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    prev_cs = 1'b1; prev_inc = 1'b1; prev_up = 1'b0;
    inc_run = 100; cs_run = 100; up_run = 100;
    repeat (3) @(negedge clk);
    chk(pot_cs_n == 1'b1, "R1", "cs_n in reset", pot_cs_n, 1);
    chk(pot_inc_n == 1'b1, "R1", "inc_n in reset", pot_inc_n, 1);
    rst_n = 1'b1;
    prev_up = pot_up;
    tick();
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(pot_cs_n && pot_inc_n, "R1", "pins idle after reset", {pot_cs_n, pot_inc_n}, 3);
  endtask

  // One command; hold_busy keeps cmd_valid high with altered fields while busy.
  task automatic run_cmd(input string tag, input logic up, input int steps, input logic store,
                         input bit hold_busy);
    int n = 0;
    mon_clear();
    exp_up = up; hold = hold_busy;
    cmd_up = up; cmd_steps = CNT_W'(steps); cmd_store = store; cmd_valid = 1'b1;
    tick();
    chk(cmd_ready == 1'b0, "R9", {tag, " ready after accept"}, cmd_ready, 0);
    if (hold_busy) begin
      cmd_steps = CNT_W'(steps + 5); cmd_up = !up; cmd_store = !store;
    end else begin
      cmd_valid = 1'b0;
    end
    while (done_cnt == 0 && n < 20000) begin tick(); n++; end
    cmd_valid = 1'b0;
    repeat (8) tick();
    chk(done_cnt == 1, "R9", {tag, " done pulses"}, done_cnt, 1);
    chk(cs_falls == 1, "R9", {tag, " selects"}, cs_falls, 1);
    chk(ready_busy == 0, "R9", {tag, " ready while selected"}, ready_busy, 0);
    chk(cmd_ready && pot_cs_n, "R1", {tag, " idle after done"}, {cmd_ready, pot_cs_n}, 3);
    chk(falls == steps, "R4", {tag, " strobe falls"}, falls, steps);
    if (steps > 0) begin
      chk(csb >= T_CS, "R2", {tag, " select before first strobe"}, csb, T_CS);
      chk(min_up >= T_DIR, "R3", {tag, " direction setup"}, min_up, T_DIR);
    end
    chk(up_chg == 0 && up_bad == 0, "R3", {tag, " direction held"}, up_chg + up_bad, 0);
    if (steps > 1 || (steps == 1 && store))
      chk(min_low >= T_IL, "R4", {tag, " low width"}, min_low, T_IL);
    if (steps > 1)
      chk(min_high >= T_IH, "R4", {tag, " high width"}, min_high, T_IH);
    chk(gap >= T_IC, "R5", {tag, " strobe-to-deselect"}, gap, T_IC);
    chk(simul == 0, "R5", {tag, " joint edges"}, simul, 0);
    if (store) begin
      chk(inc_at_rise == 1'b1, "R6", {tag, " strobe at deselect"}, inc_at_rise, 1);
      chk(desel >= T_ST, "R6", {tag, " store deselect time"}, desel, T_ST);
    end else begin
      chk(inc_at_rise == 1'b0, "R7", {tag, " strobe at deselect"}, inc_at_rise, 0);
      chk(desel >= T_NS, "R7", {tag, " deselect time"}, desel, T_NS);
    end
    if (steps == 0)
      chk(inc_at_fall == store, "R8", {tag, " strobe level at select"}, inc_at_fall, store);
  endtask

  initial begin
    test_reset();
    run_cmd("up5_nostore", 1'b1, 5, 1'b0, 1'b0);
    run_cmd("down3_store", 1'b0, 3, 1'b1, 1'b0);
    run_cmd("zero_store", 1'b1, 0, 1'b1, 1'b0);
    run_cmd("zero_nostore", 1'b0, 0, 1'b0, 1'b0);
    run_cmd("one_store", 1'b1, 1, 1'b1, 1'b0);
    run_cmd("one_nostore", 1'b0, 1, 1'b0, 1'b0);
    run_cmd("busy_ignored", 1'b1, 4, 1'b0, 1'b1);
    run_cmd("max_steps", 1'b0, 127, 1'b1, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule